// File: doc/BRIEF.md
# Three-Source Operand Read Sequencer

This block turns one accepted three-source instruction into a short, fixed series of register-file read cycles. Each read cycle can carry up to two requests, called lane A and lane B. Each request names the source slot it serves and the register index to read. Lane A serves slot 0 or slot 1; lane B serves slot 2 when it is active.

Normally slot 0 is read alone in the first cycle, and slots 1 and 2 are read together in the second cycle. When the registers of slot 1 and slot 2 fall in the same bank and the same bundle, they cannot be read together. In that case the block swaps the roles of slot 0 and slot 1: slot 1 is read first, then slot 0 is read together with slot 2.

An instruction may run in 16-lane mode. It then has two 8-lane halves, and the second half uses each source index plus one. The second half is issued in the two cycles after the first half, with the same read order. The order is chosen from the first half's registers only, and that choice is applied to both halves.

The upstream side uses a valid/ready handshake. A new instruction is held off until the read cycles of the current one have been issued. It may be accepted in the same cycle as the final read.

Top module: `opnd_read_seq`

## Requirements
- R1: After reset, rd_valid is 0 and in_ready is 1.
- R2: One clock after an instruction is accepted (in_valid and in_ready high at a rising edge), the first read cycle appears with rd_valid=1 and rd_b_en=0. Without a swap it carries rd_a_slot=0 and rd_a_idx=src0.
- R3: The read cycle after the first one has rd_a_slot=1 and rd_a_idx=src1 (no swap), together with rd_b_en=1, rd_b_slot=2 and rd_b_idx=src2.
- R4: The bank of an index is bit 0 and its bundle is bits 3:1, so a conflict means src1 and src2 agree in bits 3:0. On a conflict, rd_swapped=1 on every read cycle of the instruction. The first cycle then carries rd_a_slot=1 with src1, and the second carries rd_a_slot=0 with src0, plus slot 2 with src2.
- R5: src1 and src2 sharing a bank but not a bundle, or a bundle but not a bank, give no swap and rd_swapped=0.
- R6: With in_wide=1, two more read cycles follow with rd_half=1. They repeat the first half's pattern with every index increased by one, wrapping modulo 2^IDX_W. With in_wide=0, rd_half stays 0 and only two read cycles are issued.
- R7: In 16-lane mode the swap is decided from the first half's indices and applied to both halves.
- R8: in_ready is 0 on every read cycle but the last. On the last cycle it is 1, so an instruction accepted then starts its first read cycle on the next clock.
- R9: in_valid asserted while in_ready is 0 is ignored: the current read cycles are unchanged and no extra instruction is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_src0 | input | IDX_W | Register index of source slot 0 |
| in_src1 | input | IDX_W | Register index of source slot 1 |
| in_src2 | input | IDX_W | Register index of source slot 2 |
| in_wide | input | 1 | 16-lane mode (two 8-lane halves) |
| rd_valid | output | 1 | A read cycle is being issued |
| rd_a_slot | output | 2 | Source slot served by lane A (0 or 1) |
| rd_a_idx | output | IDX_W | Register index for lane A |
| rd_b_en | output | 1 | Lane B request active |
| rd_b_slot | output | 2 | Source slot served by lane B (always 2) |
| rd_b_idx | output | IDX_W | Register index for lane B |
| rd_half | output | 1 | Read cycle belongs to the second 8-lane half |
| rd_swapped | output | 1 | Slot 0/1 swap is in effect for this instruction |

## Verification
Two functions can fall in the same cycle: issuing the final read cycle of one instruction, and accepting the next instruction. The bench provokes this by offering a new instruction during the last read cycle of both a narrow and a wide instruction. It then expects the new instruction's first read cycle on the very next clock, with its own indices and swap decision, and no trace of the previous one. The opposite case is also covered: an offer made during a non-final cycle must leave the running sequence untouched.

// File: rtl/opnd_read_seq.sv
module opnd_read_seq #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_src0,
  input  logic [IDX_W-1:0] in_src1,
  input  logic [IDX_W-1:0] in_src2,
  input  logic             in_wide,
  output logic             rd_valid,
  output logic [1:0]       rd_a_slot,
  output logic [IDX_W-1:0] rd_a_idx,
  output logic             rd_b_en,
  output logic [1:0]       rd_b_slot,
  output logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_half,
  output logic             rd_swapped
);
  localparam int KEY_W = 4;

  logic             busy, wide_q, swap_q;
  logic [1:0]       phase;
  logic [IDX_W-1:0] s0_q, s1_q, s2_q;

  wire conflict = in_src1[KEY_W-1:0] == in_src2[KEY_W-1:0];
  wire last     = busy && phase[0] && (phase[1] || !wide_q);
  wire accept   = in_valid && in_ready;
  wire first    = !phase[0];
  wire a_is1    = ~(first ^ swap_q);
  wire [IDX_W-1:0] off = {{(IDX_W-1){1'b0}}, phase[1]};

  assign in_ready   = !busy || last;
  assign rd_valid   = busy;
  assign rd_a_slot  = {1'b0, a_is1};
  assign rd_a_idx   = busy ? ((a_is1 ? s1_q : s0_q) + off) : '0;
  assign rd_b_en    = busy && !first;
  assign rd_b_slot  = 2'd2;
  assign rd_b_idx   = rd_b_en ? (s2_q + off) : '0;
  assign rd_half    = busy && phase[1];
  assign rd_swapped = busy && swap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 2'd0;
      wide_q <= 1'b0;
      swap_q <= 1'b0;
      s0_q   <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      phase  <= 2'd0;
      wide_q <= in_wide;
      swap_q <= conflict;
      s0_q   <= in_src0;
      s1_q   <= in_src1;
      s2_q   <= in_src2;
    end else if (last) begin
      busy   <= 1'b0;
      phase  <= 2'd0;
    end else if (busy) begin
      phase  <= phase + 2'd1;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !rd_valid && in_ready);
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> rd_valid && !rd_b_en);
  p_pair_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_b_en |=> rd_valid && rd_b_en && rd_b_slot == 2'd2);
  p_conflict_swaps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_src1[3:0] == in_src2[3:0] |=> rd_swapped);
  p_no_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_src1[3:0] != in_src2[3:0] |=> !rd_swapped);
  p_half_needs_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_wide |=> ##1 !rd_half);
  p_swap_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !in_ready |=> rd_valid && $stable(rd_swapped));
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_b_en |-> !in_ready);
endmodule

// File: tb/opnd_read_seq_tb.sv
module opnd_read_seq_tb_top;
  localparam int IDX_W = 8;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_wide = 1'b0;
  logic [IDX_W-1:0] in_src0 = '0, in_src1 = '0, in_src2 = '0;
  logic in_ready, rd_valid, rd_b_en, rd_half, rd_swapped;
  logic [1:0] rd_a_slot, rd_b_slot;
  logic [IDX_W-1:0] rd_a_idx, rd_b_idx;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opnd_read_seq #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2), .in_wide(in_wide),
    .rd_valid(rd_valid), .rd_a_slot(rd_a_slot), .rd_a_idx(rd_a_idx),
    .rd_b_en(rd_b_en), .rd_b_slot(rd_b_slot), .rd_b_idx(rd_b_idx),
    .rd_half(rd_half), .rd_swapped(rd_swapped));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // snapshot of one read cycle: valid,aslot,aidx,ben,bslot,bidx,half,swap,ready
  function automatic logic [63:0] snap();
    return {28'd0, rd_valid, rd_a_slot, rd_a_idx, rd_b_en, rd_b_slot, rd_b_idx,
            rd_half, rd_swapped, in_ready};
  endfunction

  function automatic logic [63:0] mk(input bit v, input logic [1:0] as, input logic [7:0] ai,
      input bit be, input logic [7:0] bi, input bit h, input bit sw, input bit rdy);
    return {28'd0, v, as, ai, be, (be ? 2'd2 : 2'd2), bi, h, sw, rdy};
  endfunction

  task automatic offer(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input bit w);
    in_valid = 1'b1; in_src0 = a; in_src1 = b; in_src2 = c; in_wide = w;
  endtask

  // checks the read cycles of an instruction accepted at the previous edge;
  // if nxt is set, offers the next instruction on the final cycle
  task automatic expect_seq(input string req, input logic [7:0] a, input logic [7:0] b,
      input logic [7:0] c, input bit w, input bit nxt, input logic [7:0] na,
      input logic [7:0] nb, input logic [7:0] nc, input bit nw);
    bit sw = (b[3:0] == c[3:0]);
    int n = w ? 4 : 2;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      begin
        bit h = (k >= 2);
        logic [7:0] o = h ? 8'd1 : 8'd0;
        bit lst = (k == n - 1);
        if (k % 2 == 0)
          check(req, snap(), mk(1, sw ? 2'd1 : 2'd0, (sw ? b : a) + o, 0, 8'd0, h, sw, 0));
        else
          check(req, snap(), mk(1, sw ? 2'd0 : 2'd1, (sw ? a : b) + o, 1, c + o, h, sw, lst));
      end
      if (k == n - 1 && nxt) offer(na, nb, nc, nw);
    end
  endtask

  task automatic start(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input bit w);
    @(negedge clk);
    offer(a, b, c, w);
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {62'd0, rd_valid, in_ready}, 64'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {62'd0, rd_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
  endtask

  task automatic t_default_order;
    start(8'd4, 8'd7, 8'd10, 0);
    expect_seq("R2 R3 default order", 8'd4, 8'd7, 8'd10, 0, 0, 0, 0, 0, 0);
    expect_idle("R2 idle after narrow");
  endtask

  task automatic t_swap;
    start(8'd3, 8'd5, 8'd21, 0);
    expect_seq("R4 conflict swap", 8'd3, 8'd5, 8'd21, 0, 0, 0, 0, 0, 0);
    expect_idle("R4 idle");
  endtask

  task automatic t_near_miss;
    start(8'd1, 8'd2, 8'd4, 0);
    expect_seq("R5 same bank other bundle", 8'd1, 8'd2, 8'd4, 0, 0, 0, 0, 0, 0);
    expect_idle("R5 idle");
    start(8'd9, 8'd6, 8'd7, 0);
    expect_seq("R5 same bundle other bank", 8'd9, 8'd6, 8'd7, 0, 0, 0, 0, 0, 0);
    expect_idle("R5 idle 2");
  endtask

  task automatic t_wide;
    start(8'd20, 8'd33, 8'd40, 1);
    expect_seq("R6 wide no swap", 8'd20, 8'd33, 8'd40, 1, 0, 0, 0, 0, 0);
    expect_idle("R6 idle");
    start(8'd255, 8'd14, 8'd30, 1);
    expect_seq("R6 R7 wide swap wrap", 8'd255, 8'd14, 8'd30, 1, 0, 0, 0, 0, 0);
    expect_idle("R7 idle");
  endtask

  task automatic t_back_to_back;
    start(8'd2, 8'd8, 8'd9, 0);
    expect_seq("R8 narrow then accept", 8'd2, 8'd8, 8'd9, 0, 1, 8'd11, 8'd16, 8'd32, 1);
    expect_seq("R8 R7 accepted on last", 8'd11, 8'd16, 8'd32, 1, 1, 8'd50, 8'd51, 8'd52, 0);
    expect_seq("R8 after wide", 8'd50, 8'd51, 8'd52, 0, 0, 0, 0, 0, 0);
    expect_idle("R8 idle");
  endtask

  task automatic t_ignore;
    start(8'd12, 8'd13, 8'd14, 0);
    @(negedge clk);
    check("R9 first cycle", snap(), mk(1, 2'd0, 8'd12, 0, 8'd0, 0, 0, 0));
    offer(8'd60, 8'd3, 8'd19, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 pair unchanged", snap(), mk(1, 2'd1, 8'd13, 1, 8'd14, 0, 0, 1));
    @(negedge clk);
    check("R9 no extra issue", {62'd0, rd_valid, in_ready}, 64'd1);
  endtask

  initial begin
    t_reset();
    t_default_order();
    t_swap();
    t_near_miss();
    t_wide();
    t_back_to_back();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule